// File: doc/BRIEF.md
# Telephone Keypad Scanner with Debounce

This block reads a 4-row by 3-column switch matrix of the telephone kind. While the keypad is idle it drives every column high and watches the row lines. The row lines pass through a flip-flop synchronizer and are merged into a single key-down flag. When that flag has stayed high for a set number of clocks, the block drives one column at a time and waits a settle time on each. The first column that shows a row input identifies the key. The block then reports a 4-bit code together with a valid strobe that lasts one clock.

After a report, every column is driven high again. The block accepts no new key until the rows have read low for the full debounce count. Each physical press therefore yields one strobe, even if the contact bounces or the key is held down. The block expects one key at a time, and the clock that runs it must be slow enough that a few cycles outlast the contact bounce.

Top module: `keypad_scan_top`

## Requirements
- R1: A synchronous active-high reset sets `col_drive` to all ones, `key_valid` to 0 and `key_code` to 0.
- R2: While no row reads high, `col_drive` stays all ones and `key_valid` stays low.
- R3: Row inputs pass through `SYNC_STAGES` flip-flops. The scan starts only after the merged key-down flag has been high for `DEBOUNCE_CYCLES` consecutive clocks. A shorter row pulse leaves `col_drive` at all ones and raises no strobe.
- R4: During a scan, `col_drive` is one-hot. It starts at bit 0 and steps to the next higher bit, and each column is held for exactly `SETTLE_CYCLES` clocks. At all times `col_drive` is either all ones or one-hot.
- R5: Keys are numbered row-major, with the key at row r and column c sitting at bit r of `row_in` and bit c of `col_drive`. Rows 0 to 2 carry digits 1-3, 4-6 and 7-9 (code = 3r+c+1). Row 3 carries * (code 10), 0 (code 0) and # (code 11) in columns 0, 1 and 2.
- R6: `key_valid` is high for exactly one clock per report, and `key_code` holds the reported code until the next report.
- R7: On the clock of a report, `col_drive` returns to all ones. No further report occurs until the rows have read low for `DEBOUNCE_CYCLES` consecutive clocks, so a held key gives one strobe.
- R8: If no column shows a row input during the scan, for example because the key was released, the block returns to the idle probe without a strobe.
- R9: A low pulse on the rows shorter than `DEBOUNCE_CYCLES` clocks, arriving after a report, does not produce a second strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Scan clock |
| rst | input | 1 | Synchronous active-high reset |
| row_in | input | ROWS | Row sense lines from the matrix, high when a driven column connects through a closed key |
| col_drive | output | COLS | Registered column drive lines |
| key_code | output | CODE_W | Code of the last reported key |
| key_valid | output | 1 | One-clock strobe marking a new report |

## Verification
The bench uses the default parameters: a 4x3 matrix, two synchronizer stages, a three-clock column settle and a four-clock debounce. Because the debounce is short, two-clock glitches at the press and at the release fall just under the threshold, and the release-during-scan case can be placed at the exact clock when column 0 is driven. All twelve keys, including a long hold, are covered in a few thousand clocks. A keypad model that responds to `col_drive` drives the rows, and every clock the column order, the hold lengths and each strobe are compared with a queue of expected codes.

// File: rtl/kp_pkg.sv
package kp_pkg;

  typedef enum logic [1:0] {
    ST_PROBE,
    ST_CONFIRM,
    ST_COLUMN,
    ST_RELEASE
  } scan_state_t;

  // Telephone layout, row-major; the bottom row holds star, zero, hash.
  function automatic int tel_key_code(int r, int c, int rows, int cols);
    int v;
    if (r < rows - 1) begin
      v = r * cols + c + 1;
    end else if (c == 0) begin
      v = rows * cols - 2;
    end else if (c == cols - 1) begin
      v = rows * cols - 1;
    end else begin
      v = 0;
    end
    return v;
  endfunction

endpackage

// File: rtl/kp_row_sync.sv
module kp_row_sync #(
  parameter int ROWS        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [ROWS-1:0] row_in,
  output logic [ROWS-1:0] rows_sync,
  output logic            any_down
);

  logic [ROWS-1:0] stage_q [SYNC_STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SYNC_STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= row_in;
      for (int i = 1; i < SYNC_STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign rows_sync = stage_q[SYNC_STAGES-1];
  assign any_down  = |rows_sync;

endmodule

// File: rtl/kp_key_encoder.sv
module kp_key_encoder
  import kp_pkg::*;
#(
  parameter int ROWS   = 4,
  parameter int COLS   = 3,
  parameter int COL_W  = 2,
  parameter int CODE_W = 4
) (
  input  logic [ROWS-1:0]   rows,
  input  logic [COL_W-1:0]  col_idx,
  output logic              hit,
  output logic [CODE_W-1:0] code
);

  always_comb begin
    hit  = 1'b0;
    code = '0;
    // scan from the top so that the lowest active row wins
    for (int r = ROWS - 1; r >= 0; r--) begin
      if (rows[r]) begin
        hit  = 1'b1;
        code = CODE_W'(tel_key_code(r, int'(col_idx), ROWS, COLS));
      end
    end
  end

endmodule

// File: rtl/kp_scan_ctrl.sv
module kp_scan_ctrl
  import kp_pkg::*;
#(
  parameter int COLS            = 3,
  parameter int COL_W           = 2,
  parameter int CODE_W          = 4,
  parameter int SETTLE_CYCLES   = 3,
  parameter int DEBOUNCE_CYCLES = 4,
  parameter int MAX_CODE        = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              any_down,
  input  logic              hit,
  input  logic [CODE_W-1:0] hit_code,
  output logic [COLS-1:0]   col_drive,
  output logic [COL_W-1:0]  col_idx,
  output logic              key_valid,
  output logic [CODE_W-1:0] key_code
);

  localparam int CNT_MAX = (SETTLE_CYCLES > DEBOUNCE_CYCLES) ? SETTLE_CYCLES : DEBOUNCE_CYCLES;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYCLES - 1);
  localparam logic [CNT_W-1:0] DEB_LAST    = CNT_W'(DEBOUNCE_CYCLES - 1);
  localparam logic [COL_W-1:0] COL_LAST    = COL_W'(COLS - 1);

  scan_state_t      state;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_PROBE;
      cnt       <= '0;
      col_idx   <= '0;
      col_drive <= '1;
      key_valid <= 1'b0;
      key_code  <= '0;
    end else begin
      key_valid <= 1'b0;
      case (state)
        ST_PROBE: begin
          col_drive <= '1;
          cnt       <= '0;
          if (any_down) state <= ST_CONFIRM;
        end
        ST_CONFIRM: begin
          if (!any_down) begin
            state <= ST_PROBE;
            cnt   <= '0;
          end else if (cnt == DEB_LAST) begin
            state     <= ST_COLUMN;
            cnt       <= '0;
            col_idx   <= '0;
            col_drive <= COLS'(1);
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_COLUMN: begin
          if (cnt != SETTLE_LAST) begin
            cnt <= cnt + 1'b1;
          end else begin
            cnt <= '0;
            if (hit) begin
              key_valid <= 1'b1;
              key_code  <= hit_code;
              state     <= ST_RELEASE;
              col_drive <= '1;
            end else if (col_idx == COL_LAST) begin
              state     <= ST_PROBE;
              col_drive <= '1;
            end else begin
              col_idx   <= col_idx + 1'b1;
              col_drive <= col_drive << 1;
            end
          end
        end
        ST_RELEASE: begin
          col_drive <= '1;
          if (any_down) begin
            cnt <= '0;
          end else if (cnt == DEB_LAST) begin
            state <= ST_PROBE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          state     <= ST_PROBE;
          col_drive <= '1;
          cnt       <= '0;
        end
      endcase
    end
  end

  initial assert (SETTLE_CYCLES >= 2 && DEBOUNCE_CYCLES >= 1);

  p_col_shape_r4: assert property (@(posedge clk) disable iff (rst)
    (col_drive == '1) || $onehot(col_drive));

  p_single_strobe_r6: assert property (@(posedge clk) disable iff (rst)
    key_valid |=> !key_valid);

  p_code_range_r5: assert property (@(posedge clk) disable iff (rst)
    key_valid |-> (int'(key_code) <= MAX_CODE));

  p_strobe_needs_hit_r5: assert property (@(posedge clk) disable iff (rst)
    key_valid |-> $past(hit));

  p_report_idles_cols_r7: assert property (@(posedge clk) disable iff (rst)
    key_valid |-> (col_drive == '1 && state == ST_RELEASE));

  p_scan_after_confirm_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_COLUMN && $past(state) != ST_COLUMN) |-> ($past(state) == ST_CONFIRM && $past(any_down)));

  p_probe_no_strobe_r2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PROBE && $past(state) == ST_PROBE) |-> !key_valid);

endmodule

// File: rtl/keypad_scan_top.sv
module keypad_scan_top #(
  parameter int ROWS            = 4,
  parameter int COLS            = 3,
  parameter int CODE_W          = 4,
  parameter int SYNC_STAGES     = 2,
  parameter int SETTLE_CYCLES   = 3,
  parameter int DEBOUNCE_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ROWS-1:0]   row_in,
  output logic [COLS-1:0]   col_drive,
  output logic [CODE_W-1:0] key_code,
  output logic              key_valid
);

  localparam int COL_W    = (COLS > 1) ? $clog2(COLS) : 1;
  localparam int MAX_CODE = ROWS * COLS - 1;

  logic [ROWS-1:0]   rows_sync;
  logic              any_down;
  logic [COL_W-1:0]  col_idx;
  logic              hit;
  logic [CODE_W-1:0] hit_code;

  initial assert (SETTLE_CYCLES > SYNC_STAGES);

  kp_row_sync #(
    .ROWS        (ROWS),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_sync (
    .clk       (clk),
    .rst       (rst),
    .row_in    (row_in),
    .rows_sync (rows_sync),
    .any_down  (any_down)
  );

  kp_key_encoder #(
    .ROWS   (ROWS),
    .COLS   (COLS),
    .COL_W  (COL_W),
    .CODE_W (CODE_W)
  ) u_enc (
    .rows    (rows_sync),
    .col_idx (col_idx),
    .hit     (hit),
    .code    (hit_code)
  );

  kp_scan_ctrl #(
    .COLS            (COLS),
    .COL_W           (COL_W),
    .CODE_W          (CODE_W),
    .SETTLE_CYCLES   (SETTLE_CYCLES),
    .DEBOUNCE_CYCLES (DEBOUNCE_CYCLES),
    .MAX_CODE        (MAX_CODE)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .any_down  (any_down),
    .hit       (hit),
    .hit_code  (hit_code),
    .col_drive (col_drive),
    .col_idx   (col_idx),
    .key_valid (key_valid),
    .key_code  (key_code)
  );

endmodule

// File: tb/keypad_scan_top_tb.sv
`timescale 1ns/1ps
module keypad_scan_top_tb;

  localparam int ROWS   = 4;
  localparam int COLS   = 3;
  localparam int SETTLE = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] row_in;
  logic [2:0] col_drive;
  logic [3:0] key_code;
  logic       key_valid;

  always #4 clk = ~clk;

  keypad_scan_top u_dut (
    .clk       (clk),
    .rst       (rst),
    .row_in    (row_in),
    .col_drive (col_drive),
    .key_code  (key_code),
    .key_valid (key_valid)
  );

  // keypad model: a closed key links its column to its row
  logic pressed = 1'b0;
  int   pr = 0;
  int   pc = 0;
  always_comb row_in = (pressed && col_drive[pc]) ? 4'(1 << pr) : 4'b0000;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  int exp_q[$];
  bit done = 1'b0;
  bit left_probe = 1'b0;
  logic [2:0] prev_col = 3'b111;
  bit prev_valid = 1'b0;
  int held = 0;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int ref_code(int r, int c);
    if (r < 3) return 3 * r + c + 1;
    if (c == 0) return 10;
    if (c == 1) return 0;
    return 11;
  endfunction

  // every-clock comparison against the reference expectations
  always @(negedge clk) begin
    if (!rst && !done) begin
      check(col_drive == 3'b111 || $onehot(col_drive), "R4 shape", int'(col_drive), 7);
      if (col_drive != 3'b111) left_probe = 1'b1;
      if (key_valid) begin
        pulses++;
        check(!prev_valid, "R6 one-cycle strobe", 1, 0);
        check(col_drive == 3'b111, "R7 cols high on report", int'(col_drive), 7);
        if (exp_q.size() == 0) begin
          check(1'b0, "R7 unexpected strobe", int'(key_code), -1);
        end else begin
          int e;
          e = exp_q.pop_front();
          check(int'(key_code) == e, "R5 code", int'(key_code), e);
        end
      end
      if (col_drive != prev_col) begin
        if (prev_col != 3'b111)
          check(held == SETTLE, "R4 hold length", held, SETTLE);
        if (col_drive != 3'b111) begin
          logic [2:0] nx;
          nx = (prev_col == 3'b111) ? 3'b001 : (prev_col << 1);
          check(col_drive == nx, "R4 column order", int'(col_drive), int'(nx));
        end
        held = 1;
      end else begin
        held++;
      end
      prev_col   = col_drive;
      prev_valid = key_valid;
    end
  end

  task automatic cycles(int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic press_key(int r, int c, int hold);
    int p0;
    p0 = pulses;
    @(posedge clk); #1;
    pr = r; pc = c;
    exp_q.push_back(ref_code(r, c));
    pressed = 1'b1;
    for (int i = 0; i < 80 && pulses == p0; i++) begin @(posedge clk); #1; end
    cycles(hold);
    pressed = 1'b0;
    cycles(20);
    check(pulses == p0 + 1, "R7 one strobe per press", pulses - p0, 1);
    check(int'(key_code) == ref_code(r, c), "R6 code held", int'(key_code), ref_code(r, c));
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 60000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int p0;
    cycles(3);
    @(negedge clk);
    check(col_drive == 3'b111, "R1 reset cols", int'(col_drive), 7);
    check(key_valid == 1'b0, "R1 reset valid", int'(key_valid), 0);
    check(key_code == 4'd0, "R1 reset code", int'(key_code), 0);
    @(posedge clk); #1;
    rst = 1'b0;

    // R2: idle probe with nothing pressed
    cycles(20);
    check(left_probe == 1'b0, "R2 idle cols", int'(left_probe), 0);
    check(pulses == 0, "R2 idle strobes", pulses, 0);

    // R5: every key of the layout
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        press_key(r, c, 8);

    // R7: long hold gives one strobe
    press_key(2, 1, 200);

    // R3: press glitch shorter than the debounce count
    left_probe = 1'b0;
    p0 = pulses;
    pr = 0; pc = 0;
    pressed = 1'b1;
    cycles(2);
    pressed = 1'b0;
    cycles(20);
    check(left_probe == 1'b0, "R3 glitch keeps probe", int'(left_probe), 0);
    check(pulses == p0, "R3 glitch no strobe", pulses - p0, 0);

    // R8: key released just as column 0 is driven
    p0 = pulses;
    pr = 3; pc = 2;
    pressed = 1'b1;
    for (int i = 0; i < 60 && col_drive != 3'b001; i++) begin @(posedge clk); #1; end
    pressed = 1'b0;
    cycles(30);
    check(pulses == p0, "R8 abandoned scan no strobe", pulses - p0, 0);
    check(col_drive == 3'b111, "R8 back to probe", int'(col_drive), 7);

    // R9: short release bounce after a report
    p0 = pulses;
    pr = 1; pc = 1;
    exp_q.push_back(ref_code(1, 1));
    pressed = 1'b1;
    for (int i = 0; i < 80 && pulses == p0; i++) begin @(posedge clk); #1; end
    cycles(6);
    pressed = 1'b0;
    cycles(2);
    pressed = 1'b1;
    cycles(20);
    pressed = 1'b0;
    cycles(25);
    check(pulses == p0 + 1, "R9 bounce single strobe", pulses - p0, 1);
    check(exp_q.size() == 0, "R9 queue drained", exp_q.size(), 0);

    finish_run();
  end

endmodule